// File: doc/BRIEF.md
# Mode-Selected Product-to-Frequency Converter

This block turns a signed, normalised power product into two streams of single-cycle event strobes. It uses phase accumulators. An accumulator adds a mode-dependent step on every clock, and each overflow produces one strobe. The low-rate strobe feeds a pulse shaper that splits its events across two alternating phases, so the strobe runs at twice the rate of either phase. The high-rate strobe is intended for calibration. Its rate is a fixed multiple of the low-rate expression, and that multiple depends on the mode.

The mode is a 3-bit code `{rate_sel, quad_sel[1:0]}`. `rate_sel` picks the full-scale base rate: it is clk/2^CLK_SHIFT when the bit is 0, and twice that when the bit is 1. `quad_sel` picks the arithmetic:

- Codes 00 and 11 give signed (four-quadrant) operation, centred on the base rate.
- Codes 01 and 10 give magnitude-only (two-quadrant) operation, starting from zero.
- Code 11 also switches the high-rate stream to follow the channel-monitor word instead of the product.

Internally a two-state controller (CLEAR, RUN) holds the accumulators at zero after reset and after any change of mode. The controller has four transitions:

- CLEAR to RUN when the mode matches the mode seen on the previous clock.
- CLEAR to CLEAR and RUN to CLEAR when the mode differs from the previous clock.
- RUN to RUN when the mode is unchanged.

With product word k (K_W bits, two's complement, full scale ±1) and HALF = 2^(K_W-1), the accumulators are ACC_W = CLK_SHIFT + K_W - 1 bits wide. A step of one LSB is the smallest nonzero rate.

Top module: `prod_freq_dtf`

## Requirements
- R1: While reset is low and on the first edge after it rises, both strobes are 0 and both accumulators are zero. The controller starts in CLEAR, so accumulation begins on the second edge after reset is released.
- R2: In four-quadrant modes (quad_sel 00 or 11), the low-rate step is (HALF + k) shifted left by 1 + rate_sel. When an addition carries out of ACC_W bits, lo_evt is high for the clock after that edge.
- R3: In two-quadrant modes (quad_sel 01 or 10), the low-rate step is |k| shifted left by 1 + rate_sel. With k = 0, lo_evt never fires.
- R4: The high-rate step is the low-rate base (HALF + k or |k|), multiplied by 2^rate_sel and by a multiplier that depends on the mode code. The multipliers are 16, 8, 16, 32, 16, 16, 32 and 16 for codes 0 to 7. A carry out of the high-rate accumulator gives hi_evt high for one clock.
- R5: In codes 3 and 7, the high-rate base is HALF + chan_mon instead of the product term. lo_evt still follows k as in R2.
- R6: A change of mode code clears both accumulators. Both strobes are 0 on the two clocks that follow the change, and accumulation resumes on the third edge.
- R7: Each strobe is one clock wide and never fires on two consecutive clocks, provided CLK_SHIFT is at least 8.
- R8: In four-quadrant modes with k at its most negative value, lo_evt never fires. In codes 3 and 7 with chan_mon at its most negative value, hi_evt never fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 1 | Base-rate select, bit 2 of the mode code |
| quad_sel | input | 2 | Arithmetic select, bits 1:0 of the mode code |
| prod_k | input | K_W | Signed product fraction |
| chan_mon | input | K_W | Signed instantaneous channel value for the monitor modes |
| lo_evt | output | 1 | Low-rate event strobe |
| hi_evt | output | 1 | High-rate event strobe |

## Verification
The assertions assume that the mode, product and channel inputs are synchronous to the clock, and that each is sampled as a single stable value at every edge. The spacing property also assumes that CLK_SHIFT is at least 8, so that no step reaches half the accumulator range. The stimulus changes inputs only on falling edges. It holds k and the channel word constant over each counting window. It enters each window through a deliberate mode change, so that every window starts from a cleared accumulator, and the bench instance uses a parameter set that meets the spacing bound.

// File: rtl/prod_freq_dtf_pkg.sv
package prod_freq_dtf_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } dtf_state_e;

    typedef struct packed {
        logic       four_quad;
        logic       monitor;
        logic [2:0] hi_shift;
    } mode_cfg_t;

    localparam int MODE_W = 3;
    localparam int LANES  = 2;

endpackage

// File: rtl/dtf_mode_decode.sv
module dtf_mode_decode
    import prod_freq_dtf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_code,
    output mode_cfg_t         cfg
);

    // hi_shift is log2 of the high-rate multiplier for each mode code
    always_comb begin
        cfg = '0;
        unique case (mode_code)
            3'd0: cfg = '{four_quad: 1'b1, monitor: 1'b0, hi_shift: 3'd4};
            3'd1: cfg = '{four_quad: 1'b0, monitor: 1'b0, hi_shift: 3'd3};
            3'd2: cfg = '{four_quad: 1'b0, monitor: 1'b0, hi_shift: 3'd4};
            3'd3: cfg = '{four_quad: 1'b1, monitor: 1'b1, hi_shift: 3'd5};
            3'd4: cfg = '{four_quad: 1'b1, monitor: 1'b0, hi_shift: 3'd4};
            3'd5: cfg = '{four_quad: 1'b0, monitor: 1'b0, hi_shift: 3'd4};
            3'd6: cfg = '{four_quad: 1'b0, monitor: 1'b0, hi_shift: 3'd5};
            3'd7: cfg = '{four_quad: 1'b1, monitor: 1'b1, hi_shift: 3'd4};
        endcase
    end

endmodule

// File: rtl/dtf_step_gen.sv
module dtf_step_gen
    import prod_freq_dtf_pkg::*;
#(
    parameter int K_W   = 16,
    parameter int ACC_W = 34
) (
    input  mode_cfg_t                cfg,
    input  logic                     rate_sel,
    input  logic signed [K_W-1:0]    prod_k,
    input  logic signed [K_W-1:0]    chan_mon,
    output logic        [ACC_W-1:0]  lo_inc,
    output logic        [ACC_W-1:0]  hi_inc
);

    localparam int BASE_W = K_W + 1;

    logic [BASE_W-1:0] off_k;
    logic [BASE_W-1:0] off_c;
    logic [BASE_W-1:0] sx_k;
    logic [BASE_W-1:0] mag_k;
    logic [BASE_W-1:0] lo_base;
    logic [BASE_W-1:0] hi_base;
    logic [2:0]        lo_sh;
    logic [2:0]        hi_sh;

    always_comb begin
        // adding half scale to a two's-complement word is a sign-bit flip
        off_k   = {1'b0, ~prod_k[K_W-1], prod_k[K_W-2:0]};
        off_c   = {1'b0, ~chan_mon[K_W-1], chan_mon[K_W-2:0]};
        sx_k    = {prod_k[K_W-1], prod_k};
        mag_k   = sx_k[BASE_W-1] ? (~sx_k + BASE_W'(1)) : sx_k;
        lo_base = cfg.four_quad ? off_k : mag_k;
        hi_base = cfg.monitor ? off_c : lo_base;
        lo_sh   = 3'd1 + {2'b00, rate_sel};
        hi_sh   = cfg.hi_shift + {2'b00, rate_sel};
        lo_inc  = ACC_W'(lo_base) << lo_sh;
        hi_inc  = ACC_W'(hi_base) << hi_sh;
    end

endmodule

// File: rtl/dtf_phase_acc.sv
module dtf_phase_acc #(
    parameter int ACC_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc,
    output logic             carry_evt
);

    logic [ACC_W:0] sum;

    always_comb begin
        sum = {1'b0, acc} + {1'b0, inc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            carry_evt <= 1'b0;
        end else if (clear) begin
            acc       <= '0;
            carry_evt <= 1'b0;
        end else if (advance) begin
            acc       <= sum[ACC_W-1:0];
            carry_evt <= sum[ACC_W];
        end else begin
            carry_evt <= 1'b0;
        end
    end

endmodule

// File: rtl/prod_freq_dtf.sv
module prod_freq_dtf
    import prod_freq_dtf_pkg::*;
#(
    parameter int K_W       = 16,
    parameter int CLK_SHIFT = 19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rate_sel,
    input  logic [1:0]            quad_sel,
    input  logic signed [K_W-1:0] prod_k,
    input  logic signed [K_W-1:0] chan_mon,
    output logic                  lo_evt,
    output logic                  hi_evt
);

    localparam int ACC_W = CLK_SHIFT + K_W - 1;

    dtf_state_e        state_q;
    dtf_state_e        state_d;
    logic [MODE_W-1:0] mode_code;
    logic [MODE_W-1:0] mode_q;
    logic              mode_changed;
    logic              clear_acc;
    logic              advance;
    mode_cfg_t         cfg;
    logic [ACC_W-1:0]  lo_inc;
    logic [ACC_W-1:0]  hi_inc;
    logic [ACC_W-1:0]  inc_arr [LANES];
    logic [ACC_W-1:0]  acc_arr [LANES];
    logic [LANES-1:0]  evt_arr;
    logic [ACC_W-1:0]  acc_lo;
    logic [ACC_W-1:0]  acc_hi;

    assign mode_code    = {rate_sel, quad_sel};
    assign mode_changed = (mode_code != mode_q);

    // state register and mode history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_code;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: state_d = mode_changed ? ST_CLEAR : ST_RUN;
            ST_RUN:   state_d = mode_changed ? ST_CLEAR : ST_RUN;
        endcase
    end

    // controller outputs
    always_comb begin
        clear_acc = 1'b1;
        advance   = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                clear_acc = 1'b1;
                advance   = 1'b0;
            end
            ST_RUN: begin
                clear_acc = mode_changed;
                advance   = !mode_changed;
            end
        endcase
    end

    dtf_mode_decode u_decode (
        .mode_code (mode_q),
        .cfg       (cfg)
    );

    dtf_step_gen #(
        .K_W   (K_W),
        .ACC_W (ACC_W)
    ) u_step (
        .cfg      (cfg),
        .rate_sel (mode_q[MODE_W-1]),
        .prod_k   (prod_k),
        .chan_mon (chan_mon),
        .lo_inc   (lo_inc),
        .hi_inc   (hi_inc)
    );

    assign inc_arr[0] = lo_inc;
    assign inc_arr[1] = hi_inc;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dtf_phase_acc #(
            .ACC_W (ACC_W)
        ) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clear_acc),
            .advance   (advance),
            .inc       (inc_arr[g]),
            .acc       (acc_arr[g]),
            .carry_evt (evt_arr[g])
        );
    end

    assign acc_lo = acc_arr[0];
    assign acc_hi = acc_arr[1];
    assign lo_evt = evt_arr[0];
    assign hi_evt = evt_arr[1];

endmodule

// File: rtl/prod_freq_dtf_chk.sv
module prod_freq_dtf_chk #(
    parameter int K_W   = 16,
    parameter int ACC_W = 34
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rate_sel,
    input logic [1:0]            quad_sel,
    input logic signed [K_W-1:0] prod_k,
    input logic signed [K_W-1:0] chan_mon,
    input logic                  lo_evt,
    input logic                  hi_evt,
    input logic [ACC_W-1:0]      acc_lo,
    input logic [ACC_W-1:0]      acc_hi
);

    localparam logic [K_W-1:0] K_MIN = {1'b1, {(K_W-1){1'b0}}};

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lo_evt && !hi_evt && acc_lo == '0 && acc_hi == '0));

    assert_lo_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_evt |-> (acc_lo < $past(acc_lo)));

    assert_zero_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((quad_sel == 2'b01 || quad_sel == 2'b10) && prod_k == '0) |=> !lo_evt);

    assert_hi_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_evt |-> (acc_hi < $past(acc_hi)));

    assert_mode_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ({rate_sel, quad_sel} != $past({rate_sel, quad_sel})) |=> (!lo_evt && !hi_evt));

    assert_lo_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_evt |=> !lo_evt);

    assert_hi_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_evt |=> !hi_evt);

    assert_lo_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((quad_sel == 2'b00 || quad_sel == 2'b11) && prod_k == K_MIN) |=> !lo_evt);

    // R5 monitor path: the channel word alone silences the high-rate stream
    assert_hi_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (quad_sel == 2'b11 && chan_mon == K_MIN) |=> !hi_evt);

endmodule

bind prod_freq_dtf prod_freq_dtf_chk #(
    .K_W   (K_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .quad_sel (quad_sel),
    .prod_k   (prod_k),
    .chan_mon (chan_mon),
    .lo_evt   (lo_evt),
    .hi_evt   (hi_evt),
    .acc_lo   (acc_lo),
    .acc_hi   (acc_hi)
);

// File: tb/sim_prod_freq_dtf.sv
module sim_prod_freq_dtf;

    localparam int CLK_PERIOD = 10;
    localparam int K_W        = 8;
    localparam int CLK_SHIFT  = 8;
    localparam int ACC_W      = CLK_SHIFT + K_W - 1;
    localparam longint WRAP   = longint'(1) << ACC_W;
    localparam int HALF       = 1 << (K_W - 1);
    localparam int WIN        = 600;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  rate_in = 1'b0;
    logic [1:0]            quad_in = 2'b00;
    logic signed [K_W-1:0] k_in = '0;
    logic signed [K_W-1:0] c_in = '0;
    logic                  lo_evt;
    logic                  hi_evt;

    int checks = 0;
    int errors = 0;

    prod_freq_dtf #(.K_W(K_W), .CLK_SHIFT(CLK_SHIFT)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_in),
        .quad_sel (quad_in),
        .prod_k   (k_in),
        .chan_mon (c_in),
        .lo_evt   (lo_evt),
        .hi_evt   (hi_evt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint step_of(input int md, input int kv, input int cv, input bit hi);
        int  quad = md & 3;
        int  rate = (md >> 2) & 1;
        bit  four = (quad == 0 || quad == 3);
        longint lb = four ? longint'(HALF + kv) : longint'(kv < 0 ? -kv : kv);
        longint hb;
        int  mult;
        if (!hi) return lb * (rate ? 4 : 2);
        case (md)
            1:       mult = 8;
            3, 6:    mult = 32;
            default: mult = 16;
        endcase
        hb = (quad == 3) ? longint'(HALF + cv) : lb;
        return hb * mult * (rate ? 2 : 1);
    endfunction

    // behavioural reference, updated every clock
    longint m_acc_lo, m_acc_hi;
    bit     m_lo, m_hi, m_run;
    int     m_mode;

    always @(posedge clk or negedge rst_n) begin
        int cur;
        if (!rst_n) begin
            m_acc_lo = 0; m_acc_hi = 0; m_lo = 0; m_hi = 0; m_run = 0; m_mode = 0;
        end else begin
            cur = {29'd0, rate_in, quad_in};
            if (cur != m_mode) begin
                m_acc_lo = 0; m_acc_hi = 0; m_lo = 0; m_hi = 0; m_run = 0;
            end else if (!m_run) begin
                m_lo = 0; m_hi = 0; m_run = 1;
            end else begin
                m_acc_lo += step_of(cur, int'(k_in), int'(c_in), 1'b0);
                m_acc_hi += step_of(cur, int'(k_in), int'(c_in), 1'b1);
                m_lo = (m_acc_lo >= WRAP);
                m_hi = (m_acc_hi >= WRAP);
                m_acc_lo %= WRAP;
                m_acc_hi %= WRAP;
            end
            m_mode = cur;
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // per-clock comparison against the reference, plus strobe spacing (R7)
    logic prev_lo = 1'b0, prev_hi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            check_bit((quad_in == 2'b01 || quad_in == 2'b10) ? "R3" : "R2", "lo_evt vs model", lo_evt, m_lo);
            check_bit((quad_in == 2'b11) ? "R5" : "R4", "hi_evt vs model", hi_evt, m_hi);
            if (prev_lo) check_bit("R7", "lo_evt back-to-back", lo_evt, 1'b0);
            if (prev_hi) check_bit("R7", "hi_evt back-to-back", hi_evt, 1'b0);
        end
        prev_lo = lo_evt;
        prev_hi = hi_evt;
    end

    task automatic run_window(input int md, input int kv, input int cv,
                              input string lo_tag, input string hi_tag);
        int lo_cnt = 0;
        int hi_cnt = 0;
        @(negedge clk);
        {rate_in, quad_in} = 3'(md ^ 1);
        k_in = K_W'(kv);
        c_in = K_W'(cv);
        @(negedge clk);
        {rate_in, quad_in} = 3'(md);
        @(negedge clk);
        check_bit("R6", "lo_evt after mode change", lo_evt, 1'b0);
        check_bit("R6", "hi_evt after mode change", hi_evt, 1'b0);
        @(negedge clk);
        check_bit("R6", "lo_evt in clear cycle", lo_evt, 1'b0);
        check_bit("R6", "hi_evt in clear cycle", hi_evt, 1'b0);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            lo_cnt += int'(lo_evt);
            hi_cnt += int'(hi_evt);
        end
        check_int(lo_tag, $sformatf("lo count mode %0d k %0d", md, kv), lo_cnt,
                  (longint'(WIN) * step_of(md, kv, cv, 1'b0)) / WRAP);
        check_int(hi_tag, $sformatf("hi count mode %0d k %0d c %0d", md, kv, cv), hi_cnt,
                  (longint'(WIN) * step_of(md, kv, cv, 1'b1)) / WRAP);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        k_in = 8'sd40;
        repeat (3) @(negedge clk);
        check_bit("R1", "lo_evt in reset", lo_evt, 1'b0);
        check_bit("R1", "hi_evt in reset", hi_evt, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", "lo_evt first edge", lo_evt, 1'b0);
        check_bit("R1", "hi_evt first edge", hi_evt, 1'b0);
        repeat (50) @(negedge clk);

        run_window(0, 0,    0,    "R2", "R4");
        run_window(0, 100,  0,    "R2", "R4");
        run_window(1, -80,  0,    "R3", "R4");
        run_window(2, 0,    0,    "R3", "R4");
        run_window(3, 50,   -30,  "R5", "R5");
        run_window(4, -128, 0,    "R8", "R4");
        run_window(5, 127,  0,    "R3", "R4");
        run_window(6, -128, 0,    "R3", "R4");
        run_window(7, 10,   -128, "R5", "R8");
        run_window(2, 60,   0,    "R3", "R4");
        run_window(4, 90,   0,    "R2", "R4");
        run_window(7, -20,  70,   "R5", "R5");

        finish_run();
    end

endmodule